// File: doc/BRIEF.md
# Capture Dispatch Scheduler

This block sits at the centre of a multi-camera capture data path. Each capture unit gets a periodic trigger. The trigger period is set per unit by a parameter; the defaults give one frame per second and thirty frames per second at a 50 MHz clock. When a capture unit finishes, it reports the buffer it filled as a base address and a length. The scheduler turns that report into a descriptor and places it in two work queues: one for the storage writer and one for the processing element. Position and orientation records from the co-processor side go only to the storage queue.

There are three consumers: the processing element, the storage writer and the co-processor link. Each one holds at most one command at a time. A command stays valid, with a stable descriptor, until that consumer pulses done. When the processing element finishes, its result buffer becomes a new descriptor in the co-processor queue. If a queue is full, the incoming entry is dropped and that queue's saturating drop counter is incremented. The notifier is acknowledged anyway, so no capture unit is ever stalled.

Top module: `capture_dispatch`

## Requirements
- R1: Each capture trigger output is high for one cycle every `PERIOD` cycles of that unit. The first pulse is visible after `PERIOD-1` clock edges following reset release.
- R2: An accepted capture notification from unit i produces a descriptor {address, length, source id = i}. This descriptor is written to both the storage queue and the processing queue.
- R3: At most one notification is accepted per cycle. Capture units win by lowest index, and the navigation input has the lowest priority. An accepted notification is acknowledged combinationally in the same cycle. A notification that is not accepted is not acknowledged and waits.
- R4: A navigation record is written only to the storage queue, with source id 3 (all ones in the 2-bit field). It never reaches the processing element or the co-processor.
- R5: Each consumer has at most one outstanding command. Command valid and the descriptor stay stable until that consumer's done pulse. A done pulse while no command is outstanding has no effect.
- R6: The processing element is handed a job only when it is idle. Its done pulse enqueues {result address, result length, source id of the finished job} to the co-processor queue.
- R7: Each queue delivers descriptors to its consumer in the order they were accepted.
- R8: A push to a queue that is full at the start of the cycle is dropped. The notification is still acknowledged, and that queue's drop counter increments and saturates at all ones. A dropped entry is never dispatched.
- R9: In reset and right after it, no trigger, acknowledge or command valid is asserted, and all drop counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cap_trig_o | output | N_CAP | One-cycle capture trigger per unit |
| cap_done_vld_i | input | N_CAP | Capture-complete notification per unit |
| cap_done_addr_i | input | N_CAP*ADDR_W | Buffer base address per unit, unit i at slice i |
| cap_done_len_i | input | N_CAP*LEN_W | Buffer length per unit, unit i at slice i |
| cap_done_ack_o | output | N_CAP | Notification accepted |
| nav_vld_i | input | 1 | Navigation record notification |
| nav_addr_i | input | ADDR_W | Navigation record address |
| nav_len_i | input | LEN_W | Navigation record length |
| nav_ack_o | output | 1 | Navigation notification accepted |
| pe_cmd_vld_o | output | 1 | Processing command outstanding |
| pe_cmd_addr_o | output | ADDR_W | Processing job address |
| pe_cmd_len_o | output | LEN_W | Processing job length |
| pe_cmd_src_o | output | SRC_W | Processing job source id |
| pe_done_i | input | 1 | Processing job finished |
| pe_res_addr_i | input | ADDR_W | Result buffer address, sampled with done |
| pe_res_len_i | input | LEN_W | Result buffer length, sampled with done |
| st_cmd_vld_o | output | 1 | Storage command outstanding |
| st_cmd_addr_o | output | ADDR_W | Region to write to the drive |
| st_cmd_len_o | output | LEN_W | Region length |
| st_cmd_src_o | output | SRC_W | Region source id |
| st_done_i | input | 1 | Storage write finished |
| cp_cmd_vld_o | output | 1 | Co-processor command outstanding |
| cp_cmd_addr_o | output | ADDR_W | Buffer to forward |
| cp_cmd_len_o | output | LEN_W | Buffer length |
| cp_cmd_src_o | output | SRC_W | Buffer source id |
| cp_done_i | input | 1 | Forward finished |
| pe_drop_o | output | DROP_W | Processing queue drop count |
| st_drop_o | output | DROP_W | Storage queue drop count |
| cp_drop_o | output | DROP_W | Co-processor queue drop count |

## Verification
The overflow path is the hardest state to reach from the ports. A queue only fills when its consumer is busy and several notifications land back to back. The bench therefore withholds the storage done pulse and streams nine navigation records on consecutive cycles. It does this with a 4-deep queue and a 2-bit counter, so that both the drops and the counter saturation occur. Three-way contention is produced by raising both capture notifications and the navigation notification in one cycle, then removing each one as it is acknowledged.

// File: rtl/capture_dispatch_pkg.sv
package capture_dispatch_pkg;

   typedef enum logic {CONS_IDLE, CONS_BUSY} cons_state_e;

   function automatic int unsigned ptr_width(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/dispatch_trig_gen.sv
module dispatch_trig_gen #(
   parameter int unsigned PERIOD = 30
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic trig_o
);

   if (PERIOD < 2) begin : g_bad_period
      $error("dispatch_trig_gen: PERIOD must be at least 2");
   end

   localparam int unsigned CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= CW'(PERIOD - 1);
      else if (cnt_q == '0)   cnt_q <= CW'(PERIOD - 1);
      else                    cnt_q <= cnt_q - 1'b1;
   end

   assign trig_o = (cnt_q == '0);

   // R1: a trigger is never two cycles wide
   p_trig_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o |=> !trig_o);

endmodule

// File: rtl/dispatch_desc_queue.sv
module dispatch_desc_queue
   import capture_dispatch_pkg::*;
#(
   parameter int unsigned DW    = 58,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          push_i,
   input  logic [DW-1:0] push_data_i,
   input  logic          pop_i,
   output logic          empty_o,
   output logic          full_o,
   output logic [DW-1:0] head_o,
   output logic [CNT_W-1:0] drop_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dispatch_desc_queue: DEPTH must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("dispatch_desc_queue: CNT_W must be at least 1");
   end

   localparam int unsigned PTR_W = ptr_width(DEPTH);
   localparam int unsigned OCC_W = $clog2(DEPTH + 1);

   logic [DW-1:0]    slots [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [OCC_W-1:0] occ_q;
   logic             do_push, do_pop;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty_o = (occ_q == '0);
   assign full_o  = (occ_q == OCC_W'(DEPTH));
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && !empty_o;
   assign head_o  = slots[rd_q];

   always_ff @(posedge clk_i) begin
      if (do_push) slots[wr_q] <= push_data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_q   <= '0;
         rd_q   <= '0;
         occ_q  <= '0;
         drop_o <= '0;
      end else begin
         if (do_push) wr_q <= step(wr_q);
         if (do_pop)  rd_q <= step(rd_q);
         case ({do_push, do_pop})
            2'b10:   occ_q <= occ_q + OCC_W'(1);
            2'b01:   occ_q <= occ_q - OCC_W'(1);
            default: occ_q <= occ_q;
         endcase
         if (push_i && full_o && (drop_o != '1)) drop_o <= drop_o + 1'b1;
      end
   end

   // R8: occupancy never passes the depth
   p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_q <= OCC_W'(DEPTH));
   // R8: a push into a full queue bumps the counter unless saturated
   p_drop_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && full_o && (drop_o != '1)) |=> (drop_o == $past(drop_o) + 1'b1));
   // R8: a saturated counter stays saturated
   p_drop_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drop_o == '1) |=> (drop_o == '1));
   // R7: a pop with no push shrinks occupancy
   p_pop_shrinks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && !empty_o && !push_i) |=> (occ_q == $past(occ_q) - OCC_W'(1)));

endmodule

// File: rtl/dispatch_note_arb.sv
module dispatch_note_arb #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);

   always_comb begin
      logic found;
      found   = 1'b0;
      grant_o = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && !found) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dispatch_consumer.sv
module dispatch_consumer
   import capture_dispatch_pkg::*;
#(
   parameter int unsigned DW = 58
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          q_empty_i,
   input  logic [DW-1:0] q_head_i,
   output logic          q_pop_o,
   input  logic          done_i,
   output logic          cmd_vld_o,
   output logic [DW-1:0] cmd_desc_o
);

   cons_state_e state_q;

   assign q_pop_o   = (state_q == CONS_IDLE) && !q_empty_i;
   assign cmd_vld_o = (state_q == CONS_BUSY);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= CONS_IDLE;
         cmd_desc_o <= '0;
      end else if (q_pop_o) begin
         state_q    <= CONS_BUSY;
         cmd_desc_o <= q_head_i;
      end else if ((state_q == CONS_BUSY) && done_i) begin
         state_q    <= CONS_IDLE;
      end
   end

   // R5: an outstanding command holds until done
   p_cmd_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_vld_o && !done_i) |=> (cmd_vld_o && $stable(cmd_desc_o)));
   // R5: done releases the command for at least one cycle
   p_cmd_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_vld_o && done_i) |=> !cmd_vld_o);

endmodule

// File: rtl/capture_dispatch.sv
module capture_dispatch
   import capture_dispatch_pkg::*;
#(
   parameter int unsigned N_CAP   = 2,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned LEN_W   = 24,
   parameter int unsigned SRC_W   = 2,
   parameter int unsigned QDEPTH  = 8,
   parameter int unsigned DROP_W  = 8,
   parameter logic [N_CAP*32-1:0] TRIG_PERIODS = {32'd1_666_667, 32'd50_000_000}
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   output logic [N_CAP-1:0]          cap_trig_o,
   input  logic [N_CAP-1:0]          cap_done_vld_i,
   input  logic [N_CAP*ADDR_W-1:0]   cap_done_addr_i,
   input  logic [N_CAP*LEN_W-1:0]    cap_done_len_i,
   output logic [N_CAP-1:0]          cap_done_ack_o,
   input  logic                      nav_vld_i,
   input  logic [ADDR_W-1:0]         nav_addr_i,
   input  logic [LEN_W-1:0]          nav_len_i,
   output logic                      nav_ack_o,
   output logic                      pe_cmd_vld_o,
   output logic [ADDR_W-1:0]         pe_cmd_addr_o,
   output logic [LEN_W-1:0]          pe_cmd_len_o,
   output logic [SRC_W-1:0]          pe_cmd_src_o,
   input  logic                      pe_done_i,
   input  logic [ADDR_W-1:0]         pe_res_addr_i,
   input  logic [LEN_W-1:0]          pe_res_len_i,
   output logic                      st_cmd_vld_o,
   output logic [ADDR_W-1:0]         st_cmd_addr_o,
   output logic [LEN_W-1:0]          st_cmd_len_o,
   output logic [SRC_W-1:0]          st_cmd_src_o,
   input  logic                      st_done_i,
   output logic                      cp_cmd_vld_o,
   output logic [ADDR_W-1:0]         cp_cmd_addr_o,
   output logic [LEN_W-1:0]          cp_cmd_len_o,
   output logic [SRC_W-1:0]          cp_cmd_src_o,
   input  logic                      cp_done_i,
   output logic [DROP_W-1:0]         pe_drop_o,
   output logic [DROP_W-1:0]         st_drop_o,
   output logic [DROP_W-1:0]         cp_drop_o
);

   localparam int unsigned DW   = ADDR_W + LEN_W + SRC_W;
   localparam int unsigned NREQ = N_CAP + 1;
   localparam logic [SRC_W-1:0] NAV_SRC = '1;

   if (N_CAP < 1 || N_CAP >= (1 << SRC_W)) begin : g_bad_src
      $error("capture_dispatch: N_CAP must leave the all-ones source id free");
   end

   // ---------------- periodic capture triggers ----------------
   for (genvar g = 0; g < N_CAP; g++) begin : g_trig
      dispatch_trig_gen #(
         .PERIOD(int'(TRIG_PERIODS[g*32 +: 32]))
      ) u_trig (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .trig_o (cap_trig_o[g])
      );
   end

   // ---------------- notification acceptance ----------------
   logic [NREQ-1:0] grant;
   logic [DW-1:0]   sel_desc;

   dispatch_note_arb #(.N(NREQ)) u_arb (
      .req_i   ({nav_vld_i, cap_done_vld_i}),
      .grant_o (grant)
   );

   assign cap_done_ack_o = grant[N_CAP-1:0];
   assign nav_ack_o      = grant[N_CAP];

   always_comb begin
      sel_desc = '0;
      for (int i = 0; i < N_CAP; i++) begin
         if (grant[i]) begin
            sel_desc = {cap_done_addr_i[i*ADDR_W +: ADDR_W],
                        cap_done_len_i[i*LEN_W +: LEN_W], SRC_W'(i)};
         end
      end
      if (grant[N_CAP]) sel_desc = {nav_addr_i, nav_len_i, NAV_SRC};
   end

   // ---------------- queues and consumers ----------------
   logic          st_push, pe_push, cp_push;
   logic [DW-1:0] cp_data;
   logic          st_empty, pe_empty, cp_empty;
   logic          st_full, pe_full, cp_full;
   logic [DW-1:0] st_head, pe_head, cp_head;
   logic          st_pop, pe_pop, cp_pop;
   logic [DW-1:0] st_desc, pe_desc, cp_desc;

   assign st_push = |grant;
   assign pe_push = |grant[N_CAP-1:0];
   assign cp_push = pe_cmd_vld_o && pe_done_i;
   assign cp_data = {pe_res_addr_i, pe_res_len_i, pe_desc[SRC_W-1:0]};

   dispatch_desc_queue #(.DW(DW), .DEPTH(QDEPTH), .CNT_W(DROP_W)) u_st_q (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(st_push), .push_data_i(sel_desc),
      .pop_i(st_pop), .empty_o(st_empty), .full_o(st_full), .head_o(st_head),
      .drop_o(st_drop_o));

   dispatch_desc_queue #(.DW(DW), .DEPTH(QDEPTH), .CNT_W(DROP_W)) u_pe_q (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(pe_push), .push_data_i(sel_desc),
      .pop_i(pe_pop), .empty_o(pe_empty), .full_o(pe_full), .head_o(pe_head),
      .drop_o(pe_drop_o));

   dispatch_desc_queue #(.DW(DW), .DEPTH(QDEPTH), .CNT_W(DROP_W)) u_cp_q (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(cp_push), .push_data_i(cp_data),
      .pop_i(cp_pop), .empty_o(cp_empty), .full_o(cp_full), .head_o(cp_head),
      .drop_o(cp_drop_o));

   dispatch_consumer #(.DW(DW)) u_st_cons (
      .clk_i(clk_i), .rst_ni(rst_ni), .q_empty_i(st_empty), .q_head_i(st_head),
      .q_pop_o(st_pop), .done_i(st_done_i), .cmd_vld_o(st_cmd_vld_o),
      .cmd_desc_o(st_desc));

   dispatch_consumer #(.DW(DW)) u_pe_cons (
      .clk_i(clk_i), .rst_ni(rst_ni), .q_empty_i(pe_empty), .q_head_i(pe_head),
      .q_pop_o(pe_pop), .done_i(pe_done_i), .cmd_vld_o(pe_cmd_vld_o),
      .cmd_desc_o(pe_desc));

   dispatch_consumer #(.DW(DW)) u_cp_cons (
      .clk_i(clk_i), .rst_ni(rst_ni), .q_empty_i(cp_empty), .q_head_i(cp_head),
      .q_pop_o(cp_pop), .done_i(cp_done_i), .cmd_vld_o(cp_cmd_vld_o),
      .cmd_desc_o(cp_desc));

   assign st_cmd_addr_o = st_desc[DW-1 -: ADDR_W];
   assign st_cmd_len_o  = st_desc[SRC_W +: LEN_W];
   assign st_cmd_src_o  = st_desc[SRC_W-1:0];
   assign pe_cmd_addr_o = pe_desc[DW-1 -: ADDR_W];
   assign pe_cmd_len_o  = pe_desc[SRC_W +: LEN_W];
   assign pe_cmd_src_o  = pe_desc[SRC_W-1:0];
   assign cp_cmd_addr_o = cp_desc[DW-1 -: ADDR_W];
   assign cp_cmd_len_o  = cp_desc[SRC_W +: LEN_W];
   assign cp_cmd_src_o  = cp_desc[SRC_W-1:0];

   // ---------------- assertions ----------------
   // R3: only one notification is taken per cycle
   p_single_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({nav_ack_o, cap_done_ack_o}));
   // R3: navigation is taken only when no capture unit asks
   p_nav_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nav_ack_o |-> (nav_vld_i && !(|cap_done_vld_i)));

   for (genvar g = 0; g < N_CAP; g++) begin : g_chk
      // R3: acknowledge only with a pending request
      p_ack_has_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         cap_done_ack_o[g] |-> cap_done_vld_i[g]);
      if (g > 0) begin : g_prio
         // R3: a lower index always wins
         p_low_index_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cap_done_ack_o[g] |-> !(|cap_done_vld_i[g-1:0]));
      end
   end

   // R6: a processing done grows the co-processor queue unless it is full
   p_requeue_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pe_cmd_vld_o && pe_done_i && cp_full) |=> (cp_drop_o != '0));

endmodule

// File: tb/capture_dispatch_bench.sv
module capture_dispatch_bench;

   localparam int unsigned N_CAP = 2;
   localparam int unsigned AW = 32;
   localparam int unsigned LW = 24;
   localparam int unsigned SW = 2;
   localparam int unsigned QD = 4;
   localparam int unsigned DRW = 2;
   localparam int unsigned P0 = 20;
   localparam int unsigned P1 = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [N_CAP-1:0]    cap_trig, cap_vld, cap_ack;
   logic [N_CAP*AW-1:0] cap_addr;
   logic [N_CAP*LW-1:0] cap_len;
   logic nav_vld, nav_ack;
   logic [AW-1:0] nav_addr;
   logic [LW-1:0] nav_len;
   logic pe_vld, st_vld, cp_vld, pe_done, st_done, cp_done;
   logic [AW-1:0] pe_addr, st_addr, cp_addr, pe_res_addr;
   logic [LW-1:0] pe_len, st_len, cp_len, pe_res_len;
   logic [SW-1:0] pe_src, st_src, cp_src;
   logic [DRW-1:0] pe_drop, st_drop, cp_drop;

   capture_dispatch #(
      .N_CAP(N_CAP), .ADDR_W(AW), .LEN_W(LW), .SRC_W(SW), .QDEPTH(QD),
      .DROP_W(DRW), .TRIG_PERIODS({32'd7, 32'd20})
   ) u_capture_dispatch (
      .clk_i(clk), .rst_ni(rst_n), .cap_trig_o(cap_trig),
      .cap_done_vld_i(cap_vld), .cap_done_addr_i(cap_addr),
      .cap_done_len_i(cap_len), .cap_done_ack_o(cap_ack),
      .nav_vld_i(nav_vld), .nav_addr_i(nav_addr), .nav_len_i(nav_len),
      .nav_ack_o(nav_ack),
      .pe_cmd_vld_o(pe_vld), .pe_cmd_addr_o(pe_addr), .pe_cmd_len_o(pe_len),
      .pe_cmd_src_o(pe_src), .pe_done_i(pe_done), .pe_res_addr_i(pe_res_addr),
      .pe_res_len_i(pe_res_len),
      .st_cmd_vld_o(st_vld), .st_cmd_addr_o(st_addr), .st_cmd_len_o(st_len),
      .st_cmd_src_o(st_src), .st_done_i(st_done),
      .cp_cmd_vld_o(cp_vld), .cp_cmd_addr_o(cp_addr), .cp_cmd_len_o(cp_len),
      .cp_cmd_src_o(cp_src), .cp_done_i(cp_done),
      .pe_drop_o(pe_drop), .st_drop_o(st_drop), .cp_drop_o(cp_drop));

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;

   task automatic check_eq(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // consumer index: 0 processing, 1 storage, 2 co-processor
   function automatic logic vld_of(input int w);
      return (w == 0) ? pe_vld : (w == 1) ? st_vld : cp_vld;
   endfunction
   function automatic logic [AW-1:0] addr_of(input int w);
      return (w == 0) ? pe_addr : (w == 1) ? st_addr : cp_addr;
   endfunction
   function automatic logic [LW-1:0] len_of(input int w);
      return (w == 0) ? pe_len : (w == 1) ? st_len : cp_len;
   endfunction
   function automatic logic [SW-1:0] src_of(input int w);
      return (w == 0) ? pe_src : (w == 1) ? st_src : cp_src;
   endfunction

   task automatic serve(input int w, input logic [AW-1:0] ea, input logic [LW-1:0] el,
                        input logic [SW-1:0] es, input logic [AW-1:0] ra,
                        input logic [LW-1:0] rl, input string req);
      bit seen = 0;
      for (int k = 0; k < 12; k++) begin
         if (vld_of(w)) begin
            seen = 1;
            break;
         end
         tick();
      end
      check_eq(req, $sformatf("consumer %0d command seen", w), 64'(seen), 64'd1);
      check_eq(req, $sformatf("consumer %0d address", w), 64'(addr_of(w)), 64'(ea));
      check_eq(req, $sformatf("consumer %0d length", w), 64'(len_of(w)), 64'(el));
      check_eq(req, $sformatf("consumer %0d source", w), 64'(src_of(w)), 64'(es));
      pe_res_addr = ra;
      pe_res_len  = rl;
      case (w)
         0: pe_done = 1'b1;
         1: st_done = 1'b1;
         default: cp_done = 1'b1;
      endcase
      tick();
      pe_done = 1'b0;
      st_done = 1'b0;
      cp_done = 1'b0;
   endtask

   task automatic send_cap(input int u, input logic [AW-1:0] a, input logic [LW-1:0] l,
                           input string req);
      cap_vld[u] = 1'b1;
      cap_addr[u*AW +: AW] = a;
      cap_len[u*LW +: LW] = l;
      #1;
      check_eq(req, "capture ack", 64'({nav_ack, cap_ack}), 64'(1 << u));
      tick();
      cap_vld[u] = 1'b0;
   endtask

   task automatic send_nav(input logic [AW-1:0] a, input logic [LW-1:0] l, input string req);
      nav_vld = 1'b1;
      nav_addr = a;
      nav_len = l;
      #1;
      check_eq(req, "nav ack", 64'({nav_ack, cap_ack}), 64'(1 << N_CAP));
      tick();
      nav_vld = 1'b0;
   endtask

   task automatic t_reset();
      // R9: idle outputs right after reset release
      check_eq("R9", "triggers", 64'(cap_trig), 64'd0);
      check_eq("R9", "command valids", 64'({pe_vld, st_vld, cp_vld}), 64'd0);
      check_eq("R9", "acks", 64'({nav_ack, cap_ack}), 64'd0);
      check_eq("R9", "drop counters", 64'({pe_drop, st_drop, cp_drop}), 64'd0);
   endtask

   task automatic t_trigger();
      int bad0 = 0;
      int bad1 = 0;
      for (int k = 1; k <= 45; k++) begin
         tick();
         if (cap_trig[0] !== ((k % P0) == P0 - 1)) bad0++;
         if (cap_trig[1] !== ((k % P1) == P1 - 1)) bad1++;
      end
      // R1: pulse cadence of both units
      check_eq("R1", "unit 0 trigger mismatches", 64'(bad0), 64'd0);
      check_eq("R1", "unit 1 trigger mismatches", 64'(bad1), 64'd0);
   endtask

   task automatic t_capture();
      // R2 and R6: one capture to storage and processing, result to co-processor
      send_cap(0, 32'h1000_0000, 24'h000100, "R2");
      serve(1, 32'h1000_0000, 24'h000100, 2'd0, '0, '0, "R2");
      serve(0, 32'h1000_0000, 24'h000100, 2'd0, 32'h2000_0000, 24'h000080, "R2");
      serve(2, 32'h2000_0000, 24'h000080, 2'd0, '0, '0, "R6");
   endtask

   task automatic t_priority();
      // R3: three simultaneous notifiers, lowest capture index first, nav last
      cap_vld = 2'b11;
      cap_addr = {32'hB000_0000, 32'hA000_0000};
      cap_len = {24'h000B00, 24'h000A00};
      nav_vld = 1'b1;
      nav_addr = 32'hC000_0000;
      nav_len = 24'h000C00;
      #1;
      check_eq("R3", "first grant", 64'({nav_ack, cap_ack}), 64'b001);
      tick();
      cap_vld[0] = 1'b0;
      #1;
      check_eq("R3", "second grant", 64'({nav_ack, cap_ack}), 64'b010);
      tick();
      cap_vld[1] = 1'b0;
      #1;
      check_eq("R3", "third grant", 64'({nav_ack, cap_ack}), 64'b100);
      tick();
      nav_vld = 1'b0;
      // R7 and R4: storage order and nav source id 3
      serve(1, 32'hA000_0000, 24'h000A00, 2'd0, '0, '0, "R7");
      serve(1, 32'hB000_0000, 24'h000B00, 2'd1, '0, '0, "R7");
      serve(1, 32'hC000_0000, 24'h000C00, 2'd3, '0, '0, "R4");
      serve(0, 32'hA000_0000, 24'h000A00, 2'd0, 32'hA100_0000, 24'h000A10, "R6");
      serve(0, 32'hB000_0000, 24'h000B00, 2'd1, 32'hB100_0000, 24'h000B10, "R6");
      serve(2, 32'hA100_0000, 24'h000A10, 2'd0, '0, '0, "R6");
      serve(2, 32'hB100_0000, 24'h000B10, 2'd1, '0, '0, "R6");
      tick();
      tick();
      // R4: the nav record never reached processing or co-processor
      check_eq("R4", "no stray processing or co-processor command",
               64'({pe_vld, cp_vld}), 64'd0);
   endtask

   task automatic t_hold();
      // R5: done pulses while idle are ignored
      pe_done = 1'b1;
      st_done = 1'b1;
      cp_done = 1'b1;
      tick();
      pe_done = 1'b0;
      st_done = 1'b0;
      cp_done = 1'b0;
      check_eq("R5", "idle after stray done", 64'({pe_vld, st_vld, cp_vld}), 64'd0);
      send_nav(32'hD000_0000, 24'h000D00, "R5");
      send_nav(32'hD100_0000, 24'h000D10, "R5");
      for (int k = 0; k < 4; k++) tick();
      // R5: first command still held, second waits
      check_eq("R5", "held valid", 64'(st_vld), 64'd1);
      check_eq("R5", "held address", 64'(st_addr), 64'h0000_0000_D000_0000);
      serve(1, 32'hD000_0000, 24'h000D00, 2'd3, '0, '0, "R5");
      serve(1, 32'hD100_0000, 24'h000D10, 2'd3, '0, '0, "R5");
   endtask

   task automatic t_overflow();
      // R8: nine back-to-back records into a depth-4 queue with storage held
      for (int i = 0; i < 9; i++) begin
         send_nav(32'hE000_0000 + 32'(i), 24'h000010 + 24'(i), "R8");
      end
      tick();
      check_eq("R8", "storage drops saturated", 64'(st_drop), 64'd3);
      check_eq("R8", "processing drops", 64'(pe_drop), 64'd0);
      check_eq("R8", "co-processor drops", 64'(cp_drop), 64'd0);
      for (int i = 0; i < 5; i++) begin
         serve(1, 32'hE000_0000 + 32'(i), 24'h000010 + 24'(i), 2'd3, '0, '0, "R8");
      end
      tick();
      tick();
      check_eq("R8", "dropped entries never dispatched", 64'(st_vld), 64'd0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=below 20000 cycles", cyc);
         summary();
      end
   end

   initial begin
      cap_vld = '0;
      cap_addr = '0;
      cap_len = '0;
      nav_vld = 1'b0;
      nav_addr = '0;
      nav_len = '0;
      pe_done = 1'b0;
      st_done = 1'b0;
      cp_done = 1'b0;
      pe_res_addr = '0;
      pe_res_len = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_trigger();
      t_capture();
      t_priority();
      t_hold();
      t_overflow();
      summary();
   end

endmodule